// File: doc/BRIEF.md
# Instruction Pipeline Trace Reconstructor

This block is a debug-side monitor. It rebuilds the three-word instruction prefetch queue of a processor (stages A, B and C) from the processor's status strobes and its data bus. A fetch strobe latches the bus word into stage A. An advance strobe shifts the queue. A start strobe marks the stage-B word as having begun execution, so the next advance retires it into stage C. An exception strobe opens a window of exception-processing bus cycles, and an invalid qualifier voids every strobe in the cycle where it is high.

Trace hardware uses the outputs to follow the instruction stream without access to the core's internals. It sees the word and valid bit of each stage, the started mark on stage B, a one-cycle pulse for each retired opcode, a one-cycle pulse for each advance that only refills the queue, and a tag on exception-processing cycles. All state is registered. A strobe sampled at one rising edge is visible on the outputs right after that edge.

Top module: `pipe_trace_rebuild`

## Requirements
- R1: While rst_n is low, every stage word reads zero, every valid bit is 0, and started_o, done_o, fill_o and exc_o are 0.
- R2: A fetch strobe loads bus_data into stage A and sets stage A valid. Without a fetch strobe, stage A keeps its word.
- R3: An advance strobe copies the stage-A word and its valid bit into stage B. If a fetch arrives in the same cycle, B receives the old A word and A takes the bus word.
- R4: An advance strobe taken while started_o is 1 copies stage B (word and valid bit) into stage C and raises done_o for exactly one cycle. In every other cycle stage C holds its contents and done_o is 0.
- R5: An advance strobe taken while started_o is 0 leaves stage C unchanged and raises fill_o for one cycle. fill_o is 0 in every other cycle.
- R6: A start strobe sets started_o. An advance strobe clears it. When start and advance arrive together, the advance acts on the old flag and started_o ends at 0.
- R7: An exception strobe sets exc_o, and exc_o stays at 1 until a start strobe arrives without an exception strobe. If both strobes arrive in the same cycle, exc_o ends at 1.
- R8: An exception strobe clears the valid bits of stages A and B and clears started_o. A word fetched or shifted in that same cycle is still stored but marked invalid. Stage C is not affected.
- R9: While invalid_q is 1, the fetch, advance, start and exception strobes have no effect: all stage contents and flags hold, and done_o and fill_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_data | input | DATA_W | Processor data bus |
| fetch_stb | input | 1 | Instruction fetch strobe |
| advance_stb | input | 1 | Queue advance strobe |
| start_stb | input | 1 | Execution start strobe |
| exc_stb | input | 1 | Exception processing strobe |
| invalid_q | input | 1 | Voids all strobes this cycle |
| stage_a_word | output | DATA_W | Stage A contents |
| stage_a_vld | output | 1 | Stage A valid |
| stage_b_word | output | DATA_W | Stage B contents |
| stage_b_vld | output | 1 | Stage B valid |
| stage_c_word | output | DATA_W | Stage C contents |
| stage_c_vld | output | 1 | Stage C valid |
| started_o | output | 1 | Stage B word marked started |
| done_o | output | 1 | Opcode retired pulse |
| fill_o | output | 1 | Pipeline fill pulse |
| exc_o | output | 1 | Exception processing tag |

## Verification
The bench targets several same-cycle collisions. For start together with advance, a design that reads the new flag would retire the wrong word or leave started_o set. For fetch together with advance, a design that forwards the bus word would put the new word in B at once. For exception together with start, a design that lets start win would drop the tag. It also checks that an exception leaves stage C alone while voiding A and B, and that cycles with invalid_q high change nothing. A flaw in either of these would show up as a corrupted retired word or as a phantom fill or done pulse.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
   typedef struct packed {
      logic fetch;
      logic adv;
      logic start;
      logic exc;
   } strobe_t;

   localparam int unsigned STAGE_COUNT = 3;
endpackage

// File: rtl/ptr_strobe_qual.sv
module ptr_strobe_qual #(
   parameter bit MASK_FETCH = 1'b1
) (
   input  logic              fetch_i,
   input  logic              adv_i,
   input  logic              start_i,
   input  logic              exc_i,
   input  logic              invalid_i,
   output ptr_pkg::strobe_t  stb_o
);
   // Phase-one strobes are voided by the invalid qualifier; the fetch strobe
   // is optionally left ungated.
   generate
      if (MASK_FETCH) begin : g_mask_all
         assign stb_o.fetch = fetch_i & ~invalid_i;
      end else begin : g_fetch_free
         assign stb_o.fetch = fetch_i;
      end
   endgenerate

   assign stb_o.adv   = adv_i   & ~invalid_i;
   assign stb_o.start = start_i & ~invalid_i;
   assign stb_o.exc   = exc_i   & ~invalid_i;
endmodule

// File: rtl/ptr_flag_track.sv
module ptr_flag_track (
   input  logic              clk,
   input  logic              rst_n,
   input  ptr_pkg::strobe_t  stb_i,
   output logic              started_o,
   output logic              retire_o,
   output logic              done_o,
   output logic              fill_o,
   output logic              exc_o
);
   logic started_q, done_q, fill_q, exc_q;

   // Transfer decision uses the flag as it stood before this edge.
   assign retire_o = stb_i.adv & started_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         started_q <= 1'b0;
         done_q    <= 1'b0;
         fill_q    <= 1'b0;
         exc_q     <= 1'b0;
      end else begin
         done_q <= retire_o;
         fill_q <= stb_i.adv & ~started_q;
         if (stb_i.adv || stb_i.exc)
            started_q <= 1'b0;
         else if (stb_i.start)
            started_q <= 1'b1;
         if (stb_i.exc)
            exc_q <= 1'b1;
         else if (stb_i.start)
            exc_q <= 1'b0;
      end
   end

   assign started_o = started_q;
   assign done_o    = done_q;
   assign fill_o    = fill_q;
   assign exc_o     = exc_q;
endmodule

// File: rtl/ptr_stage_queue.sv
module ptr_stage_queue #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ptr_pkg::strobe_t  stb_i,
   input  logic              retire_i,
   input  logic [DATA_W-1:0] bus_i,
   output logic [DATA_W-1:0] a_word_o,
   output logic              a_vld_o,
   output logic [DATA_W-1:0] b_word_o,
   output logic              b_vld_o,
   output logic [DATA_W-1:0] c_word_o,
   output logic              c_vld_o
);
   localparam logic [DATA_W-1:0] ZERO_W = '0;

   logic [DATA_W-1:0] a_q, b_q, c_q;
   logic              av_q, bv_q, cv_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q  <= ZERO_W;
         b_q  <= ZERO_W;
         c_q  <= ZERO_W;
         av_q <= 1'b0;
         bv_q <= 1'b0;
         cv_q <= 1'b0;
      end else begin
         if (stb_i.fetch) a_q <= bus_i;
         if (stb_i.adv)   b_q <= a_q;
         if (retire_i) begin
            c_q  <= b_q;
            cv_q <= bv_q;
         end
         // An exception voids the words now in A and B, including any
         // word entering them on this edge.
         if (stb_i.exc) begin
            av_q <= 1'b0;
            bv_q <= 1'b0;
         end else begin
            if (stb_i.fetch) av_q <= 1'b1;
            if (stb_i.adv)   bv_q <= av_q;
         end
      end
   end

   assign a_word_o = a_q;
   assign a_vld_o  = av_q;
   assign b_word_o = b_q;
   assign b_vld_o  = bv_q;
   assign c_word_o = c_q;
   assign c_vld_o  = cv_q;
endmodule

// File: rtl/pipe_trace_rebuild.sv
module pipe_trace_rebuild #(
   parameter int unsigned DATA_W     = 16,
   parameter bit          MASK_FETCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              fetch_stb,
   input  logic              advance_stb,
   input  logic              start_stb,
   input  logic              exc_stb,
   input  logic              invalid_q,
   output logic [DATA_W-1:0] stage_a_word,
   output logic              stage_a_vld,
   output logic [DATA_W-1:0] stage_b_word,
   output logic              stage_b_vld,
   output logic [DATA_W-1:0] stage_c_word,
   output logic              stage_c_vld,
   output logic              started_o,
   output logic              done_o,
   output logic              fill_o,
   output logic              exc_o
);
   initial begin
      if (DATA_W < 1 || DATA_W > 64)
         $error("pipe_trace_rebuild: DATA_W must lie in 1..64");
   end

   ptr_pkg::strobe_t stb;
   logic             retire;

   ptr_strobe_qual #(.MASK_FETCH(MASK_FETCH)) u_qual (
      .fetch_i   (fetch_stb),
      .adv_i     (advance_stb),
      .start_i   (start_stb),
      .exc_i     (exc_stb),
      .invalid_i (invalid_q),
      .stb_o     (stb)
   );

   ptr_flag_track u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb_i     (stb),
      .started_o (started_o),
      .retire_o  (retire),
      .done_o    (done_o),
      .fill_o    (fill_o),
      .exc_o     (exc_o)
   );

   ptr_stage_queue #(.DATA_W(DATA_W)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb_i    (stb),
      .retire_i (retire),
      .bus_i    (bus_data),
      .a_word_o (stage_a_word),
      .a_vld_o  (stage_a_vld),
      .b_word_o (stage_b_word),
      .b_vld_o  (stage_b_vld),
      .c_word_o (stage_c_word),
      .c_vld_o  (stage_c_vld)
   );
endmodule

// File: rtl/pipe_trace_rebuild_chk.sv
module pipe_trace_rebuild_chk #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] bus_data,
   input logic              fetch_stb,
   input logic              advance_stb,
   input logic              start_stb,
   input logic              exc_stb,
   input logic              invalid_q,
   input logic [DATA_W-1:0] stage_a_word,
   input logic [DATA_W-1:0] stage_b_word,
   input logic [DATA_W-1:0] stage_c_word,
   input logic              started_o,
   input logic              done_o,
   input logic              fill_o,
   input logic              exc_o
);
   // R2
   fetch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fetch_stb && !invalid_q) |-> stage_a_word == $past(bus_data));
   // R4
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(advance_stb && !invalid_q && started_o));
   // R4
   c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(stage_c_word));
   // R5
   fill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_o |-> $past(advance_stb && !invalid_q && !started_o));
   // R6
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(advance_stb && !invalid_q) |-> !started_o);
   // R7
   exc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(exc_stb && !invalid_q) |-> exc_o);
   // R9
   invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(invalid_q) |-> ($stable(stage_a_word) && $stable(stage_b_word)
                            && $stable(started_o) && $stable(exc_o)
                            && !done_o && !fill_o));
endmodule

bind pipe_trace_rebuild pipe_trace_rebuild_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_data     (bus_data),
   .fetch_stb    (fetch_stb),
   .advance_stb  (advance_stb),
   .start_stb    (start_stb),
   .exc_stb      (exc_stb),
   .invalid_q    (invalid_q),
   .stage_a_word (stage_a_word),
   .stage_b_word (stage_b_word),
   .stage_c_word (stage_c_word),
   .started_o    (started_o),
   .done_o       (done_o),
   .fill_o       (fill_o),
   .exc_o        (exc_o)
);

// File: tb/tb_pipe_trace_rebuild.sv
`timescale 1ns/1ps
module tb_pipe_trace_rebuild;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [DW-1:0] bus_data = '0;
   logic fetch_stb = 0, advance_stb = 0, start_stb = 0, exc_stb = 0, invalid_q = 0;
   logic [DW-1:0] a_w, b_w, c_w;
   logic a_v, b_v, c_v, st, dn, fl, ex;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // model state
   logic [DW-1:0] m_a = '0, m_b = '0, m_c = '0;
   logic m_av = 0, m_bv = 0, m_cv = 0, m_st = 0, m_dn = 0, m_fl = 0, m_ex = 0;

   always #2.5 clk = ~clk;

   pipe_trace_rebuild #(.DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .bus_data(bus_data),
      .fetch_stb(fetch_stb), .advance_stb(advance_stb), .start_stb(start_stb),
      .exc_stb(exc_stb), .invalid_q(invalid_q),
      .stage_a_word(a_w), .stage_a_vld(a_v), .stage_b_word(b_w), .stage_b_vld(b_v),
      .stage_c_word(c_w), .stage_c_vld(c_v), .started_o(st), .done_o(dn),
      .fill_o(fl), .exc_o(ex)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic model_step(input logic f, input logic a, input logic s,
                             input logic e, input logic inv, input logic [DW-1:0] d);
      logic qf, qa, qs, qe;
      logic [DW-1:0] na, nb, nc;
      logic nav, nbv, ncv, nst, nex;
      qf = f & ~inv; qa = a & ~inv; qs = s & ~inv; qe = e & ~inv;
      na  = qf ? d : m_a;
      nb  = qa ? m_a : m_b;
      nc  = (qa && m_st) ? m_b : m_c;
      ncv = (qa && m_st) ? m_bv : m_cv;
      nav = qe ? 1'b0 : (qf ? 1'b1 : m_av);
      nbv = qe ? 1'b0 : (qa ? m_av : m_bv);
      nst = (qa || qe) ? 1'b0 : (qs ? 1'b1 : m_st);
      nex = qe ? 1'b1 : (qs ? 1'b0 : m_ex);
      m_dn = qa && m_st;
      m_fl = qa && !m_st;
      m_a = na; m_b = nb; m_c = nc;
      m_av = nav; m_bv = nbv; m_cv = ncv; m_st = nst; m_ex = nex;
   endtask

   task automatic compare_all();
      check("R2", "stage A word", 32'(a_w), 32'(m_a));
      check("R8", "stage A valid", 32'(a_v), 32'(m_av));
      check("R3", "stage B word", 32'(b_w), 32'(m_b));
      check("R8", "stage B valid", 32'(b_v), 32'(m_bv));
      check("R4", "stage C word", 32'(c_w), 32'(m_c));
      check("R4", "stage C valid", 32'(c_v), 32'(m_cv));
      check("R4", "done pulse", 32'(dn), 32'(m_dn));
      check("R5", "fill pulse", 32'(fl), 32'(m_fl));
      check("R6", "started flag", 32'(st), 32'(m_st));
      check("R7", "exception tag", 32'(ex), 32'(m_ex));
   endtask

   // Called at a falling edge: drive, take one rising edge, compare at next fall.
   task automatic cyc(input logic f, input logic a, input logic s, input logic e,
                      input logic inv, input logic [DW-1:0] d);
      fetch_stb = f; advance_stb = a; start_stb = s; exc_stb = e;
      invalid_q = inv; bus_data = d;
      @(posedge clk);
      #0.5 model_step(f, a, s, e, inv, d);
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      int unsigned seed;
      seed = 32'h1d2c_3b4a;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "A valid at reset", 32'(a_v), 0);
      check("R1", "C word at reset", 32'(c_w), 0);
      check("R1", "started at reset", 32'(st), 0);
      check("R1", "exc tag at reset", 32'(ex), 0);
      check("R1", "pulses at reset", 32'({dn, fl}), 0);
      rst_n = 1'b1;

      // Directed fill: two fetches, advance (fill), start, advance (retire)
      cyc(1, 0, 0, 0, 0, 16'h1111);
      cyc(1, 1, 0, 0, 0, 16'h2222);          // R3 fetch+advance collision
      check("R3", "old A shifted to B", 32'(b_w), 32'h1111);
      check("R5", "fill on unstarted advance", 32'(fl), 1);
      cyc(0, 0, 1, 0, 0, 16'h0);
      cyc(1, 1, 1, 0, 0, 16'h3333);          // R6 start+advance: uses old flag
      check("R4", "retired word in C", 32'(c_w), 32'h1111);
      check("R6", "flag cleared after start+advance", 32'(st), 0);
      cyc(0, 1, 0, 0, 0, 16'h0);
      check("R5", "C held on fill", 32'(c_w), 32'h1111);

      // R7/R8 exception voids A, B, leaves C
      cyc(0, 0, 1, 0, 0, 16'h0);
      cyc(1, 0, 1, 1, 0, 16'h4444);
      check("R8", "A invalid after exception", 32'(a_v), 0);
      check("R8", "A word still loaded", 32'(a_w), 32'h4444);
      check("R8", "started cleared by exception", 32'(st), 0);
      check("R7", "exception wins over start", 32'(ex), 1);
      check("R8", "C untouched by exception", 32'(c_w), 32'h1111);
      cyc(0, 0, 1, 0, 0, 16'h0);
      check("R7", "start clears tag", 32'(ex), 0);

      // R9 invalid voids everything
      cyc(1, 1, 1, 1, 1, 16'h5555);
      check("R9", "A unchanged under invalid", 32'(a_w), 32'h4444);
      check("R9", "no pulses under invalid", 32'({dn, fl}), 0);
      check("R9", "started kept under invalid", 32'(st), 1);

      // Constrained random
      for (int i = 0; i < 3000; i++) begin
         cyc(($urandom % 2) == 0, ($urandom % 10) < 3, ($urandom % 4) == 0,
             ($urandom % 20) == 0, ($urandom % 10) == 0, DW'($urandom));
      end
      finished = 1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (100000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule